// File: doc/BRIEF.md
# Multi-Mode Timer Wrap-Event Detector

This block is a 16-bit timer counter that counts up or down and reports when it wraps. Crossing from the all-ones value to zero is an overflow. Crossing from zero to all-ones is an underflow. A mode input selects one of five operating styles: free-running, pulse-width measurement, offset trigger generation, triangular-wave PWM and encoder compare. The mode decides which wraps are recognised, which sticky flag a wrap sets, and whether the two channels act as compare or capture channels.

A wrap is not reported in three cases:
- the counter wraps on its first update after counting starts;
- a compare match on channel 0 clears the counter, even when that compare value is all-ones;
- a capture on channel 0 clears the counter, even when the captured value is all-ones.

The block drives single-cycle interrupt pulses for channel 0, channel 1, wrap and encoder clear. Three status flags stay set until cleared: general overflow, encoder overflow and encoder underflow. The direction in triangular mode is supplied from outside by the waveform logic that turns the count.

Top module: `wrap_event_timer`

## Requirements
- R1: Mode codes are 0 free-running, 1 pulse-width measurement, 2 offset trigger, 3 triangular PWM and 4 encoder compare.
  - While `cnt_en` is 1, modes 0 to 2 count up by one per clock.
  - Modes 3 and 4 count down when `dir_down` is 1 and up when it is 0.
  - Codes 5 to 7 hold the counter.
  - While `cnt_en` is 0, the counter loads `init_val` at every clock edge.
- R2: In modes 0, 1 and 2, an overflow (all-ones to zero) sets `ovf_flag` and pulses `irq_wrap`. It leaves `enc_ovf_flag` unchanged.
- R3: In mode 4, an overflow sets `enc_ovf_flag` and pulses `irq_wrap`. It leaves `ovf_flag` unchanged.
- R4: In mode 3, an underflow (zero to all-ones) pulses `irq_wrap` and sets no flag, and an overflow is not recognised. In mode 4, an underflow sets `enc_unf_flag` and pulses `irq_wrap`.
- R5: The first counter update after `cnt_en` rises reports neither overflow nor underflow, even when the counter wraps.
- R6: In modes 0 and 4 with `match_clr_en` at 1, a counter equal to `cmp0_val` clears the counter to zero instead of stepping. No overflow is reported, even when `cmp0_val` is all-ones.
- R7: In modes 1 and 2, `cap0_stb` copies the counter into `cap0_q` and clears the counter, reporting no overflow even at all-ones. `cap1_stb` copies the counter into `cap1_q` and the count keeps stepping.
- R8: `irq_cc0` and `irq_cc1` pulse on a compare match with their channel's value in modes 0, 3 and 4, or on a capture into their channel in modes 1 and 2.
- R9: In mode 4, `enc_clr` clears the counter and pulses `irq_enc_clr` only when `enc_clr_alt` is 0. In other modes `enc_clr` has no effect. When clear causes coincide, the priority is encoder clear, then capture clear, then match clear, then the normal step.
- R10: Every interrupt output is a registered one-cycle pulse. It appears at the same clock edge as the counter update that caused it.
- R11: Flags stay set until a clear bit is pulsed: `flag_clr[0]` clears `ovf_flag`, `flag_clr[1]` clears `enc_ovf_flag` and `flag_clr[2]` clears `enc_unf_flag`. A set in the same cycle wins over the clear.
- R12: After reset, the counter, captures, flags and interrupts are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode code |
| cnt_en | input | 1 | Count enable; while 0 the counter loads `init_val` |
| dir_down | input | 1 | Count direction for modes 3 and 4 (1 = down) |
| init_val | input | 16 | Counter start value |
| cmp0_val | input | 16 | Channel 0 compare value |
| cmp1_val | input | 16 | Channel 1 compare value |
| match_clr_en | input | 1 | Channel 0 match clears the counter (modes 0, 4) |
| cap0_stb | input | 1 | Channel 0 capture-and-clear strobe |
| cap1_stb | input | 1 | Channel 1 capture strobe |
| enc_clr | input | 1 | External encoder clear strobe |
| enc_clr_alt | input | 1 | When 1, the encoder clear raises no interrupt |
| flag_clr | input | 3 | Flag clear pulses |
| count | output | 16 | Counter value |
| cap0_q | output | 16 | Channel 0 captured value |
| cap1_q | output | 16 | Channel 1 captured value |
| ovf_flag | output | 1 | General overflow flag |
| enc_ovf_flag | output | 1 | Encoder overflow flag |
| enc_unf_flag | output | 1 | Encoder underflow flag |
| irq_cc0 | output | 1 | Channel 0 interrupt pulse |
| irq_cc1 | output | 1 | Channel 1 interrupt pulse |
| irq_wrap | output | 1 | Wrap interrupt pulse |
| irq_enc_clr | output | 1 | Encoder clear interrupt pulse |

## Verification
All results are due one clock edge after the cycle in which their cause is present at the inputs or in the counter. A capture strobe, a clear or a wrap shows up in `count`, the flags and the interrupt pulses after the very next edge. A compare match is judged on the counter value held during a cycle, so its pulse appears one edge after the counter first shows the matching value. The bench drives inputs and samples outputs 1 ns after each rising edge, and checks every result at the first sample after that edge. One further sample confirms that each pulse has dropped and that each flag is still held.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;
  typedef enum logic [2:0] {
    MODE_FREE = 3'd0,
    MODE_MEAS = 3'd1,
    MODE_OFFS = 3'd2,
    MODE_TRI  = 3'd3,
    MODE_ENC  = 3'd4
  } tmode_e;

  typedef struct packed {
    logic counts;     // a defined mode: counter steps when enabled
    logic fixed_up;   // direction forced upward
    logic capture;    // channels act as capture channels
    logic compare;    // channels act as compare channels
    logic match_clr;  // channel 0 match may clear the counter
    logic ovf_ok;     // overflow recognised
    logic unf_ok;     // underflow recognised
    logic enc;        // encoder compare mode
  } mode_ctl_t;
endpackage

// File: rtl/wtd_mode_decode.sv
module wtd_mode_decode
  import wrap_timer_pkg::*;
(
  input  logic [2:0] mode,
  output mode_ctl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (mode)
      MODE_FREE: begin
        ctl.counts = 1'b1; ctl.fixed_up = 1'b1; ctl.compare = 1'b1;
        ctl.match_clr = 1'b1; ctl.ovf_ok = 1'b1;
      end
      MODE_MEAS, MODE_OFFS: begin
        ctl.counts = 1'b1; ctl.fixed_up = 1'b1; ctl.capture = 1'b1;
        ctl.ovf_ok = 1'b1;
      end
      MODE_TRI: begin
        ctl.counts = 1'b1; ctl.compare = 1'b1; ctl.unf_ok = 1'b1;
      end
      MODE_ENC: begin
        ctl.counts = 1'b1; ctl.compare = 1'b1; ctl.match_clr = 1'b1;
        ctl.ovf_ok = 1'b1; ctl.unf_ok = 1'b1; ctl.enc = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/wtd_next_count.sv
module wtd_next_count #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         step_en,
  input  logic         down,
  input  logic         clr_req,
  input  logic         first_q,
  input  logic         ovf_ok,
  input  logic         unf_ok,
  output logic [W-1:0] nxt,
  output logic         ovf_ev,
  output logic         unf_ev
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt    = cur;
    ovf_ev = 1'b0;
    unf_ev = 1'b0;
    if (step_en) begin
      if (clr_req) begin
        nxt = '0;
      end else if (down) begin
        nxt    = cur - ONE;
        unf_ev = unf_ok && (cur == '0) && !first_q;
      end else begin
        nxt    = cur + ONE;
        ovf_ev = ovf_ok && (cur == TOP) && !first_q;
      end
    end
  end
endmodule

// File: rtl/wtd_event_regs.sv
module wtd_event_regs #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ovf_ev,
  input  logic           unf_ev,
  input  logic           enc_mode,
  input  logic [NCH-1:0] ch_ev,
  input  logic           ec_ev,
  input  logic [2:0]     flag_clr,
  output logic [NCH-1:0] irq_ch,
  output logic           irq_wrap,
  output logic           irq_ec,
  output logic           ovf_flag,
  output logic           enc_ovf_flag,
  output logic           enc_unf_flag
);
  logic set_ovf, set_eovf, set_eunf;

  always_comb begin
    set_ovf  = ovf_ev && !enc_mode;
    set_eovf = ovf_ev && enc_mode;
    set_eunf = unf_ev && enc_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ch       <= '0;
      irq_wrap     <= 1'b0;
      irq_ec       <= 1'b0;
      ovf_flag     <= 1'b0;
      enc_ovf_flag <= 1'b0;
      enc_unf_flag <= 1'b0;
    end else begin
      irq_ch       <= ch_ev;
      irq_wrap     <= ovf_ev | unf_ev;
      irq_ec       <= ec_ev;
      ovf_flag     <= set_ovf  | (ovf_flag     & ~flag_clr[0]);
      enc_ovf_flag <= set_eovf | (enc_ovf_flag & ~flag_clr[1]);
      enc_unf_flag <= set_eunf | (enc_unf_flag & ~flag_clr[2]);
    end
  end
endmodule

// File: rtl/wrap_event_timer.sv
module wrap_event_timer
  import wrap_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode,
  input  logic         cnt_en,
  input  logic         dir_down,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] cmp0_val,
  input  logic [W-1:0] cmp1_val,
  input  logic         match_clr_en,
  input  logic         cap0_stb,
  input  logic         cap1_stb,
  input  logic         enc_clr,
  input  logic         enc_clr_alt,
  input  logic [2:0]   flag_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] cap0_q,
  output logic [W-1:0] cap1_q,
  output logic         ovf_flag,
  output logic         enc_ovf_flag,
  output logic         enc_unf_flag,
  output logic         irq_cc0,
  output logic         irq_cc1,
  output logic         irq_wrap,
  output logic         irq_enc_clr
);
  localparam int NCH = 2;

  mode_ctl_t      ctl;
  logic           first_q;
  logic           run;
  logic [W-1:0]   cmp_val [NCH];
  logic [NCH-1:0] cap_stb;
  logic [NCH-1:0] cap_hit;
  logic [NCH-1:0] cmp_hit;
  logic [W-1:0]   cap_q   [NCH];
  logic [NCH-1:0] irq_ch;
  logic           ec_hit, mclr_hit, clr_req, down;
  logic [W-1:0]   nxt;
  logic           ovf_ev, unf_ev;

  wtd_mode_decode u_dec (.mode(mode), .ctl(ctl));

  always_comb begin
    cmp_val[0] = cmp0_val;
    cmp_val[1] = cmp1_val;
    cap_stb    = {cap1_stb, cap0_stb};
    run        = cnt_en && ctl.counts;
    ec_hit     = run && ctl.enc && enc_clr;
    mclr_hit   = cmp_hit[0] && ctl.match_clr && match_clr_en;
    clr_req    = ec_hit | cap_hit[0] | mclr_hit;
    down       = !ctl.fixed_up && dir_down;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      cap_hit[i] = run && ctl.capture && cap_stb[i];
      cmp_hit[i] = run && ctl.compare && (count == cmp_val[i]);
    end
    always_ff @(posedge clk) begin
      if (rst) cap_q[i] <= '0;
      else if (cap_hit[i]) cap_q[i] <= count;
    end
  end

  wtd_next_count #(.W(W)) u_next (
    .cur(count), .step_en(run), .down(down), .clr_req(clr_req),
    .first_q(first_q), .ovf_ok(ctl.ovf_ok), .unf_ok(ctl.unf_ok),
    .nxt(nxt), .ovf_ev(ovf_ev), .unf_ev(unf_ev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      first_q <= 1'b1;
    end else if (!cnt_en) begin
      count   <= init_val;
      first_q <= 1'b1;
    end else if (run) begin
      count   <= nxt;
      first_q <= 1'b0;
    end
  end

  wtd_event_regs #(.NCH(NCH)) u_evt (
    .clk(clk), .rst(rst), .ovf_ev(ovf_ev), .unf_ev(unf_ev),
    .enc_mode(ctl.enc), .ch_ev(cap_hit | cmp_hit),
    .ec_ev(ec_hit && !enc_clr_alt), .flag_clr(flag_clr),
    .irq_ch(irq_ch), .irq_wrap(irq_wrap), .irq_ec(irq_enc_clr),
    .ovf_flag(ovf_flag), .enc_ovf_flag(enc_ovf_flag),
    .enc_unf_flag(enc_unf_flag)
  );

  always_comb begin
    cap0_q  = cap_q[0];
    cap1_q  = cap_q[1];
    irq_cc0 = irq_ch[0];
    irq_cc1 = irq_ch[1];
  end
endmodule

// File: rtl/wrap_event_timer_chk.sv
module wrap_event_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   mode,
  input logic         cnt_en,
  input logic [W-1:0] init_val,
  input logic         enc_clr,
  input logic         enc_clr_alt,
  input logic [2:0]   flag_clr,
  input logic [W-1:0] count,
  input logic         ovf_flag,
  input logic         enc_ovf_flag,
  input logic         enc_unf_flag,
  input logic         irq_wrap,
  input logic         irq_enc_clr
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_en) && !$past(rst)) |-> (count == $past(init_val)));

  assert_gen_ovf_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(mode) <= 3'd2 && $past(count) == TOP && count == '0));

  assert_enc_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_ovf_flag) |-> ($past(mode) == 3'd4 && count == '0));

  assert_enc_unf_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_unf_flag) |-> ($past(mode) == 3'd4 && $past(count) == '0 && count == TOP));

  assert_no_wrap_first_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !$past(cnt_en)) |=> !irq_wrap);

  assert_enc_clr_irq_R9: assert property (@(posedge clk) disable iff (rst)
    irq_enc_clr |-> ($past(mode) == 3'd4 && $past(enc_clr) && !$past(enc_clr_alt)));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr[0]) |=> ovf_flag);
endmodule

bind wrap_event_timer wrap_event_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .cnt_en(cnt_en), .init_val(init_val),
  .enc_clr(enc_clr), .enc_clr_alt(enc_clr_alt), .flag_clr(flag_clr),
  .count(count), .ovf_flag(ovf_flag), .enc_ovf_flag(enc_ovf_flag),
  .enc_unf_flag(enc_unf_flag), .irq_wrap(irq_wrap), .irq_enc_clr(irq_enc_clr)
);

// File: tb/wrap_event_timer_test.sv
module wrap_event_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic        cnt_en = 1'b0, dir_down = 1'b0;
  logic [15:0] init_val = '0, cmp0_val = 16'h1234, cmp1_val = 16'h1234;
  logic        match_clr_en = 1'b0, cap0_stb = 1'b0, cap1_stb = 1'b0;
  logic        enc_clr = 1'b0, enc_clr_alt = 1'b0;
  logic [2:0]  flag_clr = '0;
  logic [15:0] count, cap0_q, cap1_q;
  logic        ovf_flag, enc_ovf_flag, enc_unf_flag;
  logic        irq_cc0, irq_cc1, irq_wrap, irq_enc_clr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wrap_event_timer uut (
    .clk(clk), .rst(rst), .mode(mode), .cnt_en(cnt_en), .dir_down(dir_down),
    .init_val(init_val), .cmp0_val(cmp0_val), .cmp1_val(cmp1_val),
    .match_clr_en(match_clr_en), .cap0_stb(cap0_stb), .cap1_stb(cap1_stb),
    .enc_clr(enc_clr), .enc_clr_alt(enc_clr_alt), .flag_clr(flag_clr),
    .count(count), .cap0_q(cap0_q), .cap1_q(cap1_q), .ovf_flag(ovf_flag),
    .enc_ovf_flag(enc_ovf_flag), .enc_unf_flag(enc_unf_flag),
    .irq_cc0(irq_cc0), .irq_cc1(irq_cc1), .irq_wrap(irq_wrap),
    .irq_enc_clr(irq_enc_clr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wipe_flags();
    flag_clr = 3'b111;
    tick();
    flag_clr = 3'b000;
  endtask

  // Stop counting, pick the mode and preload the counter, then start.
  task automatic arm(logic [2:0] m, logic [15:0] iv);
    cnt_en = 1'b0; mode = m; init_val = iv;
    tick();
    cnt_en = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk("R12", "count", count, 0);
    chk("R12", "flags", {ovf_flag, enc_ovf_flag, enc_unf_flag}, 0);
    chk("R12", "irqs", {irq_cc0, irq_cc1, irq_wrap, irq_enc_clr}, 0);
    chk("R12", "captures", {cap0_q, cap1_q}, 0);
  endtask

  task automatic t_free_overflow();
    arm(3'd0, 16'hFFFD);
    chk("R1", "first up step", count, 16'hFFFE);
    tick();
    chk("R1", "up step", count, 16'hFFFF);
    chk("R2", "no wrap yet", irq_wrap, 0);
    tick();
    chk("R2", "wrap count", count, 0);
    chk("R2", "irq_wrap", irq_wrap, 1);
    chk("R2", "ovf_flag", ovf_flag, 1);
    chk("R2", "enc_ovf untouched", enc_ovf_flag, 0);
    tick();
    chk("R10", "irq_wrap one cycle", irq_wrap, 0);
    chk("R11", "ovf_flag held", ovf_flag, 1);
    flag_clr = 3'b001;
    tick();
    flag_clr = 3'b000;
    chk("R11", "ovf_flag cleared", ovf_flag, 0);
    cnt_en = 1'b0; init_val = 16'h0042;
    tick();
    chk("R1", "load while disabled", count, 16'h0042);
  endtask

  task automatic t_meas_overflow();
    wipe_flags();
    arm(3'd1, 16'hFFFE);
    tick();
    chk("R2", "meas mode wrap irq", irq_wrap, 1);
    chk("R2", "meas mode ovf_flag", ovf_flag, 1);
    wipe_flags();
  endtask

  task automatic t_first_suppress();
    wipe_flags();
    arm(3'd0, 16'hFFFF);
    chk("R5", "first wrap count", count, 0);
    chk("R5", "first wrap no irq", irq_wrap, 0);
    chk("R5", "first wrap no flag", ovf_flag, 0);
    wipe_flags();
    dir_down = 1'b1;
    arm(3'd4, 16'h0000);
    chk("R5", "first down count", count, 16'hFFFF);
    chk("R5", "first down no irq", irq_wrap, 0);
    chk("R5", "first down no flag", enc_unf_flag, 0);
    dir_down = 1'b0;
  endtask

  task automatic t_match_clear();
    wipe_flags();
    cmp0_val = 16'hFFFF; match_clr_en = 1'b1;
    arm(3'd0, 16'hFFFE);
    chk("R6", "reach top", count, 16'hFFFF);
    tick();
    chk("R6", "match clear count", count, 0);
    chk("R8", "irq_cc0 on match", irq_cc0, 1);
    chk("R6", "no wrap irq", irq_wrap, 0);
    chk("R6", "no ovf flag", ovf_flag, 0);
    cmp0_val = 16'h1234; match_clr_en = 1'b0;
  endtask

  task automatic t_capture();
    wipe_flags();
    arm(3'd1, 16'hFFFE);
    cap0_stb = 1'b1;
    tick();
    cap0_stb = 1'b0;
    chk("R7", "cap0 value", cap0_q, 16'hFFFF);
    chk("R7", "cap0 clears count", count, 0);
    chk("R7", "no wrap on capture clear", irq_wrap, 0);
    chk("R7", "no ovf on capture clear", ovf_flag, 0);
    chk("R8", "irq_cc0 on capture", irq_cc0, 1);
    mode = 3'd2; cap1_stb = 1'b1;
    tick();
    cap1_stb = 1'b0;
    chk("R7", "cap1 value", cap1_q, 0);
    chk("R7", "cap1 keeps counting", count, 1);
    chk("R8", "irq_cc1 on capture", irq_cc1, 1);
    chk("R8", "irq_cc0 quiet", irq_cc0, 0);
  endtask

  task automatic t_compare1();
    cmp1_val = 16'h0050;
    arm(3'd0, 16'h004E);
    tick();
    chk("R8", "count at cmp1", count, 16'h0050);
    chk("R8", "no early irq_cc1", irq_cc1, 0);
    tick();
    chk("R8", "irq_cc1 on match", irq_cc1, 1);
    chk("R8", "no clear by cmp1", count, 16'h0051);
    cmp1_val = 16'h1234;
  endtask

  task automatic t_encoder();
    wipe_flags();
    arm(3'd4, 16'hFFFE);
    tick();
    chk("R3", "enc wrap count", count, 0);
    chk("R3", "enc irq_wrap", irq_wrap, 1);
    chk("R3", "enc_ovf_flag", enc_ovf_flag, 1);
    chk("R3", "ovf_flag untouched", ovf_flag, 0);
    dir_down = 1'b1;
    tick();
    chk("R4", "enc underflow count", count, 16'hFFFF);
    chk("R4", "enc underflow irq", irq_wrap, 1);
    chk("R4", "enc_unf_flag", enc_unf_flag, 1);
    dir_down = 1'b0;
    wipe_flags();
    arm(3'd4, 16'hFFFE);
    flag_clr = 3'b010;
    tick();
    flag_clr = 3'b000;
    chk("R11", "set beats clear", enc_ovf_flag, 1);
    wipe_flags();
  endtask

  task automatic t_triangle();
    wipe_flags();
    dir_down = 1'b1;
    arm(3'd3, 16'h0001);
    chk("R1", "tri down step", count, 0);
    tick();
    chk("R4", "tri underflow count", count, 16'hFFFF);
    chk("R4", "tri underflow irq", irq_wrap, 1);
    chk("R4", "tri sets no flag", {ovf_flag, enc_ovf_flag, enc_unf_flag}, 0);
    dir_down = 1'b0;
    tick();
    chk("R4", "tri overflow count", count, 0);
    chk("R4", "tri overflow ignored", irq_wrap, 0);
    chk("R4", "tri overflow no flag", ovf_flag, 0);
  endtask

  task automatic t_enc_clear();
    arm(3'd4, 16'h0100);
    enc_clr = 1'b1; enc_clr_alt = 1'b0;
    tick();
    chk("R9", "enc clear count", count, 0);
    chk("R9", "enc clear irq", irq_enc_clr, 1);
    enc_clr_alt = 1'b1;
    tick();
    chk("R9", "alt clear count", count, 0);
    chk("R9", "alt clear no irq", irq_enc_clr, 0);
    enc_clr = 1'b0; enc_clr_alt = 1'b0;
    tick();
    chk("R9", "resume count", count, 1);
    arm(3'd0, 16'h0010);
    enc_clr = 1'b1;
    tick();
    enc_clr = 1'b0;
    chk("R9", "free mode ignores clear", count, 16'h0012);
    chk("R9", "free mode no irq", irq_enc_clr, 0);
  endtask

  task automatic t_hold_mode();
    arm(3'd5, 16'h0077);
    tick();
    chk("R1", "undefined mode holds", count, 16'h0077);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_free_overflow();
    t_meas_overflow();
    t_first_suppress();
    t_match_clear();
    t_capture();
    t_compare1();
    t_encoder();
    t_triangle();
    t_enc_clear();
    t_hold_mode();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule